// File: doc/BRIEF.md
# Edge Triggered Timer Capture Unit

This block pairs a free-running up-counting timer with a capture register. When a chosen transition arrives on a trigger input, the register takes the timer's value. The trigger can come from a dedicated capture pin. It can also come from the two quadrature lines of a neighbouring timer, taken one at a time or both together. Each trigger raises a sticky request flag, and it can also reset the timer to zero. Software can therefore read edge-to-edge intervals directly from the capture register, or read absolute timestamps from it.

All three raw trigger lines are asynchronous. Each one passes through a two-stage synchroniser and a stability filter. The filter only accepts a new level once it has held for four clocks, so pulses shorter than that are discarded. When capture is switched off, the capture pin still works as a clear source and a request source for the timer. The neighbouring timer's lines only matter while capture is on.

Top module: `ecap_timer_unit`

## Requirements
- R1: After reset, `timer_o`, `capture_o` and `flag_o` are all zero.
- R2: When there is no clearing event, `timer_o` goes up by one on every clock and wraps from FFFFh to 0000h.
- R3: After the two synchroniser stages, a trigger line's new level is accepted only once it has been steady for four consecutive clocks. A raw pulse of three clocks is ignored, and a raw pulse of four clocks is accepted.
- R4: Suppose a raw trigger line changes between two clock edges. The resulting event acts on the seventh rising clock edge after that change. At that edge `capture_o` takes the `timer_o` value present just before it.
- R5: `edge_sel_i` has these encodings: 00 means no edge is active, 01 means rising edges, 10 means falling edges, and 11 means both edges.
- R6: When `src_sel_i`=0, the trigger is `cap_pin_i`. When `src_sel_i`=1, the trigger is the neighbouring lines: `nbr_mask_i` bit 0 enables `nbr_a_i` and bit 1 enables `nbr_b_i`. A line that is not selected has no effect.
- R7: With `clr_on_cap_i`=1, an event latches the current timer value and loads the timer with 0000h on the same edge. With `clr_on_cap_i`=0, the timer keeps counting.
- R8: Every event sets `flag_o`, and it stays set until a `flag_clr_i` strobe. If an event and the strobe arrive in the same cycle, the flag stays set.
- R9: With `cap_en_i`=0, `capture_o` holds its value. An active edge on `cap_pin_i` still sets the flag, and it still clears the timer when `clr_on_cap_i`=1, whatever `src_sel_i` is. The neighbouring lines have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | Raw dedicated capture pin |
| nbr_a_i | input | 1 | Raw neighbouring timer line A |
| nbr_b_i | input | 1 | Raw neighbouring timer line B |
| cap_en_i | input | 1 | Capture enable |
| src_sel_i | input | 1 | 0: capture pin, 1: neighbouring lines |
| nbr_mask_i | input | 2 | Bit 0 enables line A, bit 1 enables line B |
| edge_sel_i | input | 2 | 00 none, 01 rising, 10 falling, 11 both |
| clr_on_cap_i | input | 1 | Clear timer on event |
| flag_clr_i | input | 1 | Strobe that clears the request flag |
| timer_o | output | 16 | Timer value |
| capture_o | output | 16 | Capture register |
| flag_o | output | 1 | Sticky request flag |

## Verification
The hardest situation to reach from the ports is the single cycle in which an event and a flag-clear strobe land together. Close behind it is the exact boundary between a rejected three-clock pulse and an accepted four-clock pulse. The stimulus reaches both by counting clock edges from the moment a raw line changes. After six edges it samples the timer, and it raises the clear strobe in the one cycle before the seventh edge. It then checks the captured value, the timer and the flag at that exact edge. Pulse widths are set in whole cycles at falling edges, so each case lands exactly on one side of the boundary.

// File: rtl/ecap_unit_pkg.sv
package ecap_unit_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // trigger channel indices
  localparam int unsigned CH_PIN = 0;
  localparam int unsigned CH_A   = 1;
  localparam int unsigned CH_B   = 2;
  localparam int unsigned N_CH   = 3;

endpackage

// File: rtl/ecap_in_filter.sv
module ecap_in_filter #(
  parameter int unsigned STABLE_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (STABLE_CLKS > 2) ? $clog2(STABLE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CLKS - 1);

  logic          sync1_q, sync1_d;
  logic          sync2_q, sync2_d;
  logic          lvl_q, lvl_d;
  logic          prev_q, prev_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sync1_d = raw_i;
    sync2_d = sync1_q;
    prev_d  = lvl_q;
    lvl_d   = lvl_q;
    cnt_d   = '0;
    if (sync2_q != lvl_q) begin
      if (cnt_q == LAST) begin
        lvl_d = sync2_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      lvl_q   <= 1'b0;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= sync1_d;
      sync2_q <= sync2_d;
      lvl_q   <= lvl_d;
      prev_q  <= prev_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;

  // R3: accepted level only moves after a full stability window
  a_r3_level_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) == LAST && $past(sync2_q) == lvl_q));

  a_r3_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

endmodule

// File: rtl/ecap_trig_sel.sv
module ecap_trig_sel
  import ecap_unit_pkg::*;
(
  input  logic [N_CH-1:0] rise_i,
  input  logic [N_CH-1:0] fall_i,
  input  edge_mode_e      edge_mode_i,
  input  logic            src_sel_i,
  input  logic [1:0]      nbr_mask_i,
  input  logic            cap_en_i,
  output logic            cap_evt_o,
  output logic            any_evt_o
);
  logic            rise_act, fall_act;
  logic [N_CH-1:0] hit;
  logic            pin_hit, nbr_hit, sel_hit;

  always_comb begin
    rise_act = (edge_mode_i == EDGE_RISE) || (edge_mode_i == EDGE_BOTH);
    fall_act = (edge_mode_i == EDGE_FALL) || (edge_mode_i == EDGE_BOTH);
    for (int i = 0; i < int'(N_CH); i++) begin
      hit[i] = (rise_act & rise_i[i]) | (fall_act & fall_i[i]);
    end
    pin_hit = hit[CH_PIN];
    nbr_hit = (nbr_mask_i[0] & hit[CH_A]) | (nbr_mask_i[1] & hit[CH_B]);
    sel_hit = src_sel_i ? nbr_hit : pin_hit;
    cap_evt_o = cap_en_i & sel_hit;
    any_evt_o = cap_en_i ? sel_hit : pin_hit;
  end

endmodule

// File: rtl/ecap_tmr_core.sv
module ecap_tmr_core #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_evt_i,
  input  logic             any_evt_i,
  input  logic             clr_on_cap_i,
  input  logic             flag_clr_i,
  output logic [TMR_W-1:0] timer_o,
  output logic [TMR_W-1:0] capture_o,
  output logic             flag_o
);
  logic [TMR_W-1:0] timer_q, timer_d;
  logic [TMR_W-1:0] capture_q, capture_d;
  logic             flag_q, flag_d;
  logic             tmr_clear;
  logic             cap_load;

  always_comb begin
    tmr_clear = any_evt_i & clr_on_cap_i;
    cap_load  = cap_evt_i;
    timer_d   = tmr_clear ? '0 : timer_q + 1'b1;
    capture_d = capture_q;
    if (cap_load) begin
      capture_d = timer_q;
    end
    flag_d = flag_q;
    if (any_evt_i) begin
      flag_d = 1'b1;
    end else if (flag_clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q   <= '0;
      capture_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      timer_q   <= timer_d;
      capture_q <= capture_d;
      flag_q    <= flag_d;
    end
  end

  assign timer_o   = timer_q;
  assign capture_o = capture_q;
  assign flag_o    = flag_q;

  // R2: plain increment when nothing clears
  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(any_evt_i && clr_on_cap_i) |=> (timer_q == $past(timer_q) + TMR_W'(1)));

  // R7: clear follows an event with the clear bit set
  a_r7_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_evt_i && clr_on_cap_i) |=> (timer_q == '0));

  // R4: captured value is the pre-edge timer value
  a_r4_capture_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> (capture_q == $past(timer_q)));

  // R9: capture register holds without a capture event
  a_r9_capture_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt_i |=> $stable(capture_q));

  // R8: event always leaves the flag set, even against a clear strobe
  a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_evt_i |=> flag_q);

  a_r8_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_evt_i && flag_clr_i) |=> !flag_q);

endmodule

// File: rtl/ecap_timer_unit.sv
module ecap_timer_unit
  import ecap_unit_pkg::*;
#(
  parameter int unsigned TMR_W       = 16,
  parameter int unsigned STABLE_CLKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_pin_i,
  input  logic             nbr_a_i,
  input  logic             nbr_b_i,
  input  logic             cap_en_i,
  input  logic             src_sel_i,
  input  logic [1:0]       nbr_mask_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             clr_on_cap_i,
  input  logic             flag_clr_i,
  output logic [TMR_W-1:0] timer_o,
  output logic [TMR_W-1:0] capture_o,
  output logic             flag_o
);
  logic [N_CH-1:0] raw_vec;
  logic [N_CH-1:0] rise_vec;
  logic [N_CH-1:0] fall_vec;
  logic            cap_evt;
  logic            any_evt;
  edge_mode_e      edge_mode;

  assign raw_vec[CH_PIN] = cap_pin_i;
  assign raw_vec[CH_A]   = nbr_a_i;
  assign raw_vec[CH_B]   = nbr_b_i;
  assign edge_mode       = edge_mode_e'(edge_sel_i);

  for (genvar g = 0; g < int'(N_CH); g++) begin : g_flt
    ecap_in_filter #(
      .STABLE_CLKS(STABLE_CLKS)
    ) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_vec[g]),
      .rise_o(rise_vec[g]),
      .fall_o(fall_vec[g])
    );
  end

  ecap_trig_sel u_sel (
    .rise_i     (rise_vec),
    .fall_i     (fall_vec),
    .edge_mode_i(edge_mode),
    .src_sel_i  (src_sel_i),
    .nbr_mask_i (nbr_mask_i),
    .cap_en_i   (cap_en_i),
    .cap_evt_o  (cap_evt),
    .any_evt_o  (any_evt)
  );

  ecap_tmr_core #(
    .TMR_W(TMR_W)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_evt_i   (cap_evt),
    .any_evt_i   (any_evt),
    .clr_on_cap_i(clr_on_cap_i),
    .flag_clr_i  (flag_clr_i),
    .timer_o     (timer_o),
    .capture_o   (capture_o),
    .flag_o      (flag_o)
  );

  // R5: edge mode 00 never produces an event
  a_r5_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b00) |-> !any_evt);

  // R9: no capture while capture is disabled
  a_r9_no_capture_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |-> !cap_evt);

  // R6: a capture always comes from the selected source
  a_r6_src_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && !src_sel_i) |-> (rise_vec[CH_PIN] || fall_vec[CH_PIN]));

endmodule

// File: tb/ecap_timer_unit_tb_top.sv
module ecap_timer_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cap_pin, nbr_a, nbr_b;
  logic        cap_en, src_sel, clr_on_cap, flag_clr;
  logic [1:0]  nbr_mask, edge_sel;
  logic [15:0] timer, capture;
  logic        flag;

  int checks = 0;
  int errors = 0;

  ecap_timer_unit dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cap_pin_i   (cap_pin),
    .nbr_a_i     (nbr_a),
    .nbr_b_i     (nbr_b),
    .cap_en_i    (cap_en),
    .src_sel_i   (src_sel),
    .nbr_mask_i  (nbr_mask),
    .edge_sel_i  (edge_sel),
    .clr_on_cap_i(clr_on_cap),
    .flag_clr_i  (flag_clr),
    .timer_o     (timer),
    .capture_o   (capture),
    .flag_o      (flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_line(input int ch, input logic lvl);
    case (ch)
      0: cap_pin = lvl;
      1: nbr_a   = lvl;
      default: nbr_b = lvl;
    endcase
  endtask

  task automatic setup(input logic en, input logic src, input logic [1:0] mask,
                       input logic [1:0] edge_m, input logic clr);
    cap_en = en; src_sel = src; nbr_mask = mask; edge_sel = edge_m; clr_on_cap = clr;
    @(negedge clk);
  endtask

  // change one raw line at a falling edge and check the seventh rising edge (R4)
  task automatic fire(input int ch, input logic lvl, input logic e_cap, input logic e_flag,
                      input logic e_clr, input logic collide, input string req);
    logic [15:0] cap0, t0, exp_t;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    cap0 = capture;
    set_line(ch, lvl);
    repeat (6) @(posedge clk);
    @(negedge clk);
    t0 = timer;
    if (collide) flag_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flag_clr = 1'b0;
    exp_t = e_clr ? 16'h0000 : t0 + 16'h0001;
    check(req, "capture", int'(capture), int'(e_cap ? t0 : cap0));
    check(req, "flag", int'(flag), int'(e_flag));
    check(req, "timer", int'(timer), int'(exp_t));
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "timer after reset", int'(timer), 0);
    check("R1", "capture after reset", int'(capture), 0);
    check("R1", "flag after reset", int'(flag), 0);
  endtask

  task automatic t_count;
    logic [15:0] t0;
    setup(1'b1, 1'b0, 2'b00, 2'b00, 1'b0);
    t0 = timer;
    repeat (10) @(negedge clk);
    check("R2", "ten clocks", int'(timer), int'(t0 + 16'd10));
    t0 = timer;
    repeat (65536) @(negedge clk);
    check("R2", "full wrap", int'(timer), int'(t0));
  endtask

  task automatic t_edges;
    // rising only, no clear (R4, R5, R7)
    setup(1'b1, 1'b0, 2'b00, 2'b01, 1'b0);
    fire(0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 rising capture");
    fire(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 falling ignored in rise mode");
    // falling only, with clear
    setup(1'b1, 1'b0, 2'b00, 2'b10, 1'b1);
    fire(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 rising ignored in fall mode");
    fire(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7 falling capture with clear");
    // both edges
    setup(1'b1, 1'b0, 2'b00, 2'b11, 1'b0);
    fire(0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 both mode rise");
    fire(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 both mode fall");
    // no edge selected, clear bit set
    setup(1'b1, 1'b0, 2'b00, 2'b00, 1'b1);
    fire(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 mode 00 rise");
    fire(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 mode 00 fall");
  endtask

  task automatic pulse(input int width, input logic e_hit);
    logic [15:0] cap0;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    cap0 = capture;
    cap_pin = 1'b1;
    repeat (width) @(negedge clk);
    cap_pin = 1'b0;
    repeat (14) @(negedge clk);
    check("R3", $sformatf("flag after %0d-clock pulse", width), int'(flag), int'(e_hit));
    if (!e_hit) check("R3", "capture after short pulse", int'(capture), int'(cap0));
    else check("R3", "capture moved after long pulse", int'(capture != cap0), 1);
  endtask

  task automatic t_filter;
    setup(1'b1, 1'b0, 2'b00, 2'b01, 1'b0);
    pulse(3, 1'b0);
    pulse(4, 1'b1);
  endtask

  task automatic t_neighbour;
    setup(1'b1, 1'b1, 2'b01, 2'b11, 1'b0);
    fire(1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 line A enabled");
    fire(2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 line B masked");
    fire(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 pin ignored with src 1");
    setup(1'b1, 1'b1, 2'b10, 2'b11, 1'b1);
    fire(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 line A masked");
    fire(2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6 line B enabled");
    setup(1'b1, 1'b1, 2'b11, 2'b11, 1'b0);
    fire(1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 both lines A");
    fire(2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 both lines B");
    setup(1'b1, 1'b0, 2'b11, 2'b11, 1'b0);
    fire(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 pin with src 0");
    fire(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 line A ignored with src 0");
  endtask

  task automatic t_flag;
    setup(1'b1, 1'b0, 2'b00, 2'b01, 1'b0);
    fire(0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R8 event beats clear strobe");
    repeat (20) @(negedge clk);
    check("R8", "flag sticky", int'(flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R8", "flag cleared by strobe", int'(flag), 0);
    cap_pin = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_disabled;
    setup(1'b0, 1'b0, 2'b11, 2'b01, 1'b1);
    fire(0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9 pin clears and flags while off");
    setup(1'b0, 1'b1, 2'b11, 2'b10, 1'b1);
    fire(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 line A inert while off");
    fire(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9 pin active with src 1 while off");
    setup(1'b0, 1'b0, 2'b11, 2'b01, 1'b0);
    fire(0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 pin flags without clear");
  endtask

  initial begin
    rst_n = 1'b0;
    cap_pin = 1'b0; nbr_a = 1'b0; nbr_b = 1'b0;
    cap_en = 1'b0; src_sel = 1'b0; nbr_mask = 2'b00; edge_sel = 2'b00;
    clr_on_cap = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_count();
    t_edges();
    t_filter();
    t_neighbour();
    t_flag();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule